// File: doc/BRIEF.md
# Prioritised Interrupt Router

This block gathers a set of global interrupt request lines and routes them to several hart contexts. Every source has a programmable priority. Every context has an enable bit for each source and a priority threshold of its own. A gateway stage latches each request into a pending bit. It can sense a rising edge or a level, chosen per source when the block is built. For each context an arbiter picks the best pending source that is enabled there and whose priority is above that context's threshold. The arbiter then drives that context's interrupt line.

Software services an interrupt in two steps. A read of the context's claim register returns the winning source number and takes that source. The source stays blocked until the same number is written back to the claim register, so no separate masking is needed. Source number 0 is reserved and means "nothing to service".

Top module: `irq_router`

## Requirements
- R1: After reset every interrupt line is low, and every priority, enable, threshold and claim read returns 0.
- R2: The priority of source k sits at byte address 4*k and holds PRIO_W bits. Upper write bits are dropped. Address 0 (source 0) reads 0 and ignores writes.
- R3: The enables of context c sit at 0x2000 + 0x80*c. Source k is bit k%32 of the word at offset 4*(k/32). Bit 0 of word 0 always reads 0.
- R4: The threshold of context c sits at 0x200000 + 0x1000*c. A source is eligible for that context only if its priority is strictly greater than the threshold, so priority 0 never interrupts.
- R5: Among eligible sources the highest priority wins. On equal priority the lowest source number wins.
- R6: A read of offset +4 in a context's block returns the winning source number, or 0 if none is eligible. The data appears one cycle after the read strobe. The read claims at most one source.
- R7: A claim clears the source's pending bit and blocks the source until it is completed. The context line drops, and a further claim does not return that source.
- R8: Writing a source number to the claim offset completes it only if that source is currently claimed and is enabled in the writing context. Any other completion write has no effect.
- R9: A level-sensed source whose request is still high at completion pends again. One whose request is low does not.
- R10: An edge-sensed source pends only on a rising edge of its request. A request held high through completion does not pend it again.
- R11: Enables are separate per context. A source enabled only in context 1 raises only line 1 and can be claimed only there.
- R12: Interrupt lines are registered. A level request raised before clock edge n shows on the line after edge n+1 and not after edge n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (claims when aimed at a claim register) |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_re |
| src_req | input | NSRC | Request lines, bit k-1 carries source k |
| irq_o | output | NCTX | One interrupt line per context |

## Verification
On every cycle the assertions check the following. A claimed source is never pending. A source is released only by a completion. Edge and level sources pend only under their own trigger conditions. Each arbiter's winner is pending, enabled and above threshold. One bus access claims or completes at most one source. The bench scenarios are needed for the rest: priority ordering and tie-breaking, the exact register layout, ignored completions, re-pending after completion, routing to separate contexts, and the two-cycle line latency.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned EN_BASE    = 32'h0000_2000;
  localparam int unsigned EN_STRIDE  = 32'h0000_0080;
  localparam int unsigned CTX_BASE   = 32'h0020_0000;
  localparam int unsigned CTX_STRIDE = 32'h0000_1000;
  localparam int unsigned THR_OFS    = 32'h0;
  localparam int unsigned CLAIM_OFS  = 32'h4;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_PRIO,
    RG_EN,
    RG_THR,
    RG_CLAIM
  } reg_region_e;
endpackage

// File: rtl/irq_gateway.sv
module irq_gateway #(
  parameter bit EDGE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic claim,
  input  logic complete,
  output logic pending,
  output logic busy
);
  logic prev_q;
  logic trig;

  always_ff @(posedge clk) prev_q <= req;

  assign trig = EDGE ? (req && !prev_q) : req;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      busy    <= 1'b0;
    end else if (claim) begin
      pending <= 1'b0;
      busy    <= 1'b1;
    end else begin
      if (complete && busy) busy <= 1'b0;
      if (!pending && !busy && trig) pending <= 1'b1;
    end
  end

  AST_CLAIM_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    claim |=> (busy && !pending)); // R7
  AST_BUSY_NOT_PENDING: assert property (@(posedge clk) disable iff (rst)
    busy |-> !pending); // R7
  AST_RELEASE_ON_COMPLETE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(complete)); // R8

  generate
    if (EDGE) begin : g_edge_chk
      AST_EDGE_NEEDS_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(pending) |-> ($past(req) && !$past(req, 2))); // R10
    end else begin : g_level_chk
      AST_LEVEL_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(pending) |-> $past(req)); // R9
    end
  endgenerate
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC   = 8,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NSRC:1]                pend,
  input  logic [NSRC:1]                en,
  input  logic [NSRC:1][PRIO_W-1:0]    prio,
  input  logic [PRIO_W-1:0]            thresh,
  output logic [ID_W-1:0]              best_id
);
  logic [PRIO_W-1:0] best_prio;

  // Walk upward from source 1; a strict compare keeps the lower ID on ties,
  // and seeding with the threshold enforces "strictly above threshold".
  always_comb begin
    best_prio = thresh;
    best_id   = '0;
    for (int s = 1; s <= NSRC; s++) begin
      if (pend[s] && en[s] && (prio[s] > best_prio)) begin
        best_prio = prio[s];
        best_id   = ID_W'(s);
      end
    end
  end

  AST_WINNER_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
    (best_id != '0) |-> (pend[best_id] && en[best_id])); // R11
  AST_WINNER_ABOVE_THRESH: assert property (@(posedge clk) disable iff (rst)
    (best_id != '0) |-> (prio[best_id] > thresh)); // R4
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_ctrl_pkg::*;
#(
  parameter int              NSRC      = 8,
  parameter int              NCTX      = 2,
  parameter int              PRIO_W    = 3,
  parameter int              ADDR_W    = 24,
  parameter logic [NSRC-1:0] EDGE_MASK = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  input  logic [NSRC-1:0]   src_req,
  output logic [NCTX-1:0]   irq_o
);
  localparam int ID_W     = $clog2(NSRC + 1);
  localparam int EN_WORDS = (NSRC + 32) / 32;

  logic [NSRC:1][PRIO_W-1:0] prio_q;
  logic [NCTX-1:0][NSRC:1]   en_q;
  logic [NCTX-1:0][PRIO_W-1:0] thr_q;
  logic [NCTX-1:0][ID_W-1:0] best_id;
  logic [NSRC:1]             pending_v, busy_v, claim_vec, cmpl_vec;
  logic [NCTX-1:0]           irq_q;
  logic [31:0]               rdata_q, rd_word;

  // Address decode
  logic [31:0] a32, rel, sel_src, sel_ctx, sel_word;
  reg_region_e rgn;

  always_comb begin
    a32      = 32'(bus_addr);
    rel      = '0;
    sel_src  = '0;
    sel_ctx  = '0;
    sel_word = '0;
    rgn      = RG_NONE;
    if (a32 < EN_BASE) begin
      sel_src = a32 >> 2;
      if (a32[1:0] == 2'b00 && sel_src <= 32'(NSRC)) rgn = RG_PRIO;
    end else if (a32 < CTX_BASE) begin
      rel      = a32 - EN_BASE;
      sel_ctx  = rel / EN_STRIDE;
      sel_word = (rel % EN_STRIDE) >> 2;
      if (rel[1:0] == 2'b00 && sel_ctx < 32'(NCTX) && sel_word < 32'(EN_WORDS))
        rgn = RG_EN;
    end else begin
      rel     = a32 - CTX_BASE;
      sel_ctx = rel / CTX_STRIDE;
      if (sel_ctx < 32'(NCTX)) begin
        if ((rel % CTX_STRIDE) == THR_OFS)        rgn = RG_THR;
        else if ((rel % CTX_STRIDE) == CLAIM_OFS) rgn = RG_CLAIM;
      end
    end
  end

  // Register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (bus_we) begin
      case (rgn)
        RG_PRIO: begin
          for (int s = 1; s <= NSRC; s++)
            if (32'(s) == sel_src) prio_q[s] <= bus_wdata[PRIO_W-1:0];
        end
        RG_EN: begin
          for (int c = 0; c < NCTX; c++)
            for (int s = 1; s <= NSRC; s++)
              if (32'(c) == sel_ctx && 32'(s / 32) == sel_word)
                en_q[c][s] <= bus_wdata[s % 32];
        end
        RG_THR: begin
          for (int c = 0; c < NCTX; c++)
            if (32'(c) == sel_ctx) thr_q[c] <= bus_wdata[PRIO_W-1:0];
        end
        default: ;
      endcase
    end
  end

  // Read mux
  always_comb begin
    rd_word = '0;
    case (rgn)
      RG_PRIO: begin
        for (int s = 1; s <= NSRC; s++)
          if (32'(s) == sel_src) rd_word = 32'(prio_q[s]);
      end
      RG_EN: begin
        for (int c = 0; c < NCTX; c++)
          for (int s = 1; s <= NSRC; s++)
            if (32'(c) == sel_ctx && 32'(s / 32) == sel_word)
              rd_word[s % 32] = en_q[c][s];
      end
      RG_THR: begin
        for (int c = 0; c < NCTX; c++)
          if (32'(c) == sel_ctx) rd_word = 32'(thr_q[c]);
      end
      RG_CLAIM: begin
        for (int c = 0; c < NCTX; c++)
          if (32'(c) == sel_ctx) rd_word = 32'(best_id[c]);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_re) rdata_q <= rd_word;
  end
  assign bus_rdata = rdata_q;

  // Claim and completion strobes per source
  always_comb begin
    claim_vec = '0;
    cmpl_vec  = '0;
    for (int c = 0; c < NCTX; c++) begin
      for (int s = 1; s <= NSRC; s++) begin
        if (rgn == RG_CLAIM && 32'(c) == sel_ctx) begin
          if (bus_re && best_id[c] == ID_W'(s)) claim_vec[s] = 1'b1;
          if (bus_we && bus_wdata == 32'(s) && en_q[c][s]) cmpl_vec[s] = 1'b1;
        end
      end
    end
  end

  generate
    for (genvar s = 1; s <= NSRC; s++) begin : g_gw
      irq_gateway #(.EDGE(EDGE_MASK[s-1])) u_gw (
        .clk      (clk),
        .rst      (rst),
        .req      (src_req[s-1]),
        .claim    (claim_vec[s]),
        .complete (cmpl_vec[s]),
        .pending  (pending_v[s]),
        .busy     (busy_v[s])
      );
    end

    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
      irq_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .pend    (pending_v),
        .en      (en_q[c]),
        .prio    (prio_q),
        .thresh  (thr_q[c]),
        .best_id (best_id[c])
      );

      always_ff @(posedge clk) begin
        if (rst) irq_q[c] <= 1'b0;
        else     irq_q[c] <= (best_id[c] != '0);
      end
    end
  endgenerate

  assign irq_o = irq_q;

  AST_ONE_CLAIM: assert property (@(posedge clk) disable iff (rst)
    $onehot0(claim_vec)); // R6
  AST_ONE_COMPLETE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmpl_vec)); // R8
endmodule

// File: tb/sim_irq_router.sv
module sim_irq_router;
  localparam int NSRC = 8;
  localparam int NCTX = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [NSRC-1:0] src_req = '0;
  logic [NCTX-1:0] irq_o;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  irq_router #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(3), .ADDR_W(24),
               .EDGE_MASK(8'b1100_0000)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .src_req(src_req), .irq_o(irq_o)
  );

  function automatic logic [23:0] a_prio(int s);  return 24'(4 * s); endfunction
  function automatic logic [23:0] a_en(int c);    return 24'(32'h2000 + 32'h80 * c); endfunction
  function automatic logic [23:0] a_thr(int c);   return 24'(32'h20_0000 + 32'h1000 * c); endfunction
  function automatic logic [23:0] a_claim(int c); return 24'(32'h20_0004 + 32'h1000 * c); endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [23:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [23:0] a, output logic [31:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic drain0();
    logic [31:0] x;
    for (int i = 0; i < 10; i++) begin
      rd(a_claim(0), x);
      if (x == 0) break;
      wr(a_claim(0), x);
    end
  endtask

  // {req[5:0], threshold[2:0], expected id[3:0], expected line}
  localparam logic [13:0] VEC [8] = '{
    {6'b000001, 3'd0, 4'd1, 1'b1},
    {6'b000001, 3'd2, 4'd0, 1'b0},
    {6'b000011, 3'd0, 4'd2, 1'b1},
    {6'b000110, 3'd0, 4'd2, 1'b1},
    {6'b001111, 3'd4, 4'd4, 1'b1},
    {6'b100000, 3'd0, 4'd0, 1'b0},
    {6'b010100, 3'd0, 4'd3, 1'b1},
    {6'b010000, 3'd1, 4'd0, 1'b0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    tick(4);
    rst = 1'b0;
    tick(1);

    // R1 reset state
    check("R1 lines after reset", 32'(irq_o), 32'h0);
    rd(a_prio(2), d);  check("R1 priority after reset", d, 32'h0);
    rd(a_claim(0), d); check("R1 claim after reset", d, 32'h0);
    rd(a_thr(1), d);   check("R1 threshold after reset", d, 32'h0);

    // R2 priority layout and width
    wr(a_prio(0), 32'h7);   rd(a_prio(0), d); check("R2 source 0 priority", d, 32'h0);
    wr(a_prio(3), 32'hFF);  rd(a_prio(3), d); check("R2 priority width", d, 32'h7);

    // R3 enable layout
    wr(a_en(1), 32'hFFFF_FFFF); rd(a_en(1), d); check("R3 enable word ctx1", d, 32'h1FE);
    wr(a_en(1), 32'h100);       rd(a_en(1), d); check("R3 enable rewrite", d, 32'h100);

    // priorities s1..s8 = 2,5,5,7,1,0,4,6 ; ctx0 enables s1..s7
    wr(a_prio(1), 2); wr(a_prio(2), 5); wr(a_prio(3), 5); wr(a_prio(4), 7);
    wr(a_prio(5), 1); wr(a_prio(6), 0); wr(a_prio(7), 4); wr(a_prio(8), 6);
    wr(a_en(0), 32'hFE);

    // R4 R5 R6 table
    for (int i = 0; i < 8; i++) begin
      wr(a_thr(0), 32'(VEC[i][7:5]));
      src_req[5:0] = VEC[i][13:8];
      tick(3);
      check($sformatf("R4 R5 line vector %0d", i), 32'(irq_o[0]), 32'(VEC[i][0]));
      rd(a_claim(0), d);
      check($sformatf("R5 R6 claim id vector %0d", i), d, 32'(VEC[i][4:1]));
      if (d != 0) wr(a_claim(0), d);
      src_req[5:0] = '0;
      wr(a_thr(0), 0);
      drain0();
    end

    // R7 R8 R9 with level source 1
    src_req[0] = 1'b1;
    tick(3);
    check("R7 line before claim", 32'(irq_o[0]), 32'h1);
    rd(a_claim(0), d); check("R6 claim source 1", d, 32'h1);
    tick(2);
    check("R7 line drops after claim", 32'(irq_o[0]), 32'h0);
    rd(a_claim(0), d); check("R7 blocked source not reclaimed", d, 32'h0);
    wr(a_claim(0), 2);
    wr(a_claim(1), 1);
    tick(3);
    check("R8 bad completions ignored", 32'(irq_o[0]), 32'h0);
    wr(a_claim(0), 1);
    tick(3);
    check("R9 level re-pends after completion", 32'(irq_o[0]), 32'h1);
    rd(a_claim(0), d); check("R9 reclaim source 1", d, 32'h1);
    src_req[0] = 1'b0;
    wr(a_claim(0), 1);
    tick(3);
    check("R9 low level does not re-pend", 32'(irq_o[0]), 32'h0);

    // R10 edge source 7
    src_req[6] = 1'b1;
    tick(3);
    rd(a_claim(0), d); check("R10 edge claim", d, 32'h7);
    wr(a_claim(0), 7);
    tick(3);
    check("R10 held edge no re-pend line", 32'(irq_o[0]), 32'h0);
    rd(a_claim(0), d); check("R10 held edge no re-pend claim", d, 32'h0);
    src_req[6] = 1'b0; tick(1);
    src_req[6] = 1'b1; tick(3);
    check("R10 new rising edge pends", 32'(irq_o[0]), 32'h1);
    rd(a_claim(0), d); check("R10 new edge claim", d, 32'h7);
    wr(a_claim(0), 7);
    src_req[6] = 1'b0;

    // R11 source 8 enabled only in context 1
    src_req[7] = 1'b1; tick(2);
    src_req[7] = 1'b0; tick(2);
    check("R11 only line 1 raised", 32'(irq_o), 32'h2);
    rd(a_claim(0), d); check("R11 ctx0 cannot claim", d, 32'h0);
    rd(a_claim(1), d); check("R11 ctx1 claims", d, 32'h8);
    wr(a_claim(1), 8);

    // R12 line latency with level source 5
    src_req[4] = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R12 line not after first edge", 32'(irq_o[0]), 32'h0);
    @(posedge clk); @(negedge clk);
    check("R12 line after second edge", 32'(irq_o[0]), 32'h1);
    rd(a_claim(0), d); check("R12 claim source 5", d, 32'h5);
    src_req[4] = 1'b0;
    wr(a_claim(0), 5);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule